// File: doc/BRIEF.md
# Pending-writeback queue with register hazard lookup

This block sits between the execute and writeback stages of a small in-order pipeline. Each instruction that finishes execute leaves one record here, and writeback retires the records in arrival order. A record is one of four kinds: an ALU result that carries data and a target register, an outstanding load that carries only its target register, a store marker, and a host marker that carries a payload word.

The queue also answers register lookups in the same cycle they are asked. Issue logic presents the two source-register indices of the instruction it wants to send. Each lookup reports whether any record still waiting in the queue will write that register. The combined `hazard` output tells issue to hold the instruction. Only records that write a register (ALU result, load) count as matches. Slots that have already been retired never match, whatever they still hold.

Top module: `wbq_scoreboard`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0, `can_push` is 1, both hit outputs and `hazard` are 0, and the head fields read 0 whenever the queue is empty.
- R2: Records leave in the order they were accepted. `head_kind`/`head_dest`/`head_data` show the oldest record, and an accepted `pop` moves the head to the next record after the clock edge. The kind encoding is 0 = ALU result, 1 = load, 2 = store, 3 = host, and a host record's payload travels in the data field.
- R3: A lookup of index r hits while an occupied record of kind 0 (ALU result) has target r.
- R4: A lookup of index r hits while an occupied record of kind 1 (load) has target r.
- R5: Records of kind 2 (store) and kind 3 (host) never cause a hit, whatever their dest and data fields hold.
- R6: The two lookup ports are independent and are evaluated in the same cycle on different indices.
- R7: `hazard` is 1 exactly when at least one of the two lookups hits.
- R8: A slot that has been retired by a pop no longer causes a hit.
- R9: A lookup in the same cycle as the pop of a matching record still hits in that cycle.
- R10: With the default depth of 4, once four records are held, `can_push` is 0 and a further push is dropped: the record is never stored and never matches.
- R11: A pop while the queue is empty has no effect: the queue stays empty and a push in that same cycle is still accepted.
- R12: `clear` empties the queue at the next clock edge. It takes priority over a push or pop in the same cycle, and the record pushed in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Request to append a record |
| push_kind | input | 2 | Record kind: 0 ALU, 1 load, 2 store, 3 host |
| push_dest | input | 5 | Target register of the record |
| push_data | input | 32 | Result data or host payload |
| can_push | output | 1 | Queue has room; a push is accepted |
| pop | input | 1 | Retire the head record |
| clear | input | 1 | Discard all records |
| head_valid | output | 1 | Queue holds at least one record |
| head_kind | output | 2 | Kind of the oldest record |
| head_dest | output | 5 | Target register of the oldest record |
| head_data | output | 32 | Data of the oldest record |
| src_a_idx | input | 5 | Lookup index, first operand |
| src_b_idx | input | 5 | Lookup index, second operand |
| src_a_hit | output | 1 | First operand has a pending writer |
| src_b_hit | output | 1 | Second operand has a pending writer |
| hazard | output | 1 | Either operand has a pending writer |

## Verification
The hardest case to reach is a stale slot after the pointers have wrapped. To reach it, the queue must be filled, partly drained and refilled, so that retired slots still hold matching targets while the occupied region straddles the end of the array. Directed steps set up the plain cases first: a lookup in the same cycle as a pop, a push dropped when the queue is full, and clear together with push. After that, a long mixed run drives targets and lookup indices from a small range of registers, so that wrap-around with leftover matching data happens often. Every cycle is compared against a behavioural queue model.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int REG_IDX_W = 5;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    WBK_ALU   = 2'd0,
    WBK_LOAD  = 2'd1,
    WBK_STORE = 2'd2,
    WBK_HOST  = 2'd3
  } wb_kind_e;

  typedef struct packed {
    wb_kind_e               kind;
    logic [REG_IDX_W-1:0]   dest;
    logic [DATA_W-1:0]      data;
  } wb_rec_t;

  function automatic logic writes_reg(wb_kind_e k);
    return (k == WBK_ALU) || (k == WBK_LOAD);
  endfunction
endpackage

// File: rtl/wbq_ctrl.sv
module wbq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             clear,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [DEPTH-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wr_d, rd_d;
  logic             upd_en;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    push_ok = push_req && !full && !clear;
    pop_ok  = pop_req && !empty && !clear;
    upd_en  = push_ok || pop_ok || clear;
  end

  always_comb begin
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = push_ok ? ptr_inc(wr_ptr) : wr_ptr;
      rd_d  = pop_ok  ? ptr_inc(rd_ptr) : rd_ptr;
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      wr_ptr <= wr_d;
      rd_ptr <= rd_d;
      cnt_q  <= cnt_d;
    end
  end

  // Slot i is live when its distance from the head is below the count.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off    = (i >= int'(rd_ptr)) ? (i - int'(rd_ptr)) : (i + DEPTH - int'(rd_ptr));
      occ[i] = (off < int'(cnt_q));
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req && !clear) |=> full);

  a_r11_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_req) |=> empty);

  a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && occ == '0));
endmodule

// File: rtl/wbq_store.sv
module wbq_store
  import wbq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_ptr,
  input  wb_rec_t          wdata,
  input  logic [PTR_W-1:0] rd_ptr,
  output wb_rec_t          head,
  output wb_rec_t          slots [DEPTH]
);
  // Payload storage carries no reset: the occupancy mask guards every use.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = we && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slots[g] <= wdata;
    end
  end

  assign head = slots[rd_ptr];
endmodule

// File: rtl/wbq_search.sv
module wbq_search
  import wbq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wb_rec_t              slots [DEPTH],
  input  logic [DEPTH-1:0]     occ,
  input  logic [REG_IDX_W-1:0] idx,
  output logic                 hit
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = occ[g] && writes_reg(slots[g].kind) && (slots[g].dest == idx);
  end

  assign hit = |match;

  a_r8_no_live_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !hit);
endmodule

// File: rtl/wbq_scoreboard.sv
module wbq_scoreboard
  import wbq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_valid,
  input  logic [1:0]           push_kind,
  input  logic [REG_IDX_W-1:0] push_dest,
  input  logic [DATA_W-1:0]    push_data,
  output logic                 can_push,
  input  logic                 pop,
  input  logic                 clear,
  output logic                 head_valid,
  output logic [1:0]           head_kind,
  output logic [REG_IDX_W-1:0] head_dest,
  output logic [DATA_W-1:0]    head_data,
  input  logic [REG_IDX_W-1:0] src_a_idx,
  input  logic [REG_IDX_W-1:0] src_b_idx,
  output logic                 src_a_hit,
  output logic                 src_b_hit,
  output logic                 hazard
);
  logic             push_ok, pop_ok, full, empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DEPTH-1:0] occ;
  wb_rec_t          wrec, head;
  wb_rec_t          slots [DEPTH];
  logic [REG_IDX_W-1:0] s_idx [2];
  logic [1:0]       s_hit;

  wbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_valid), .pop_req(pop),
    .clear(clear), .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .occ(occ), .full(full), .empty(empty)
  );

  assign wrec.kind = wb_kind_e'(push_kind);
  assign wrec.dest = push_dest;
  assign wrec.data = push_data;

  wbq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok), .wr_ptr(wr_ptr), .wdata(wrec),
    .rd_ptr(rd_ptr), .head(head), .slots(slots)
  );

  assign s_idx[0] = src_a_idx;
  assign s_idx[1] = src_b_idx;

  for (genvar p = 0; p < 2; p++) begin : g_port
    wbq_search #(.DEPTH(DEPTH)) u_search (
      .clk(clk), .rst_n(rst_n), .slots(slots), .occ(occ),
      .idx(s_idx[p]), .hit(s_hit[p])
    );
  end

  assign src_a_hit  = s_hit[0];
  assign src_b_hit  = s_hit[1];
  assign hazard     = |s_hit;
  assign can_push   = !full;
  assign head_valid = !empty;
  assign head_kind  = empty ? 2'd0 : head.kind;
  assign head_dest  = empty ? '0 : head.dest;
  assign head_data  = empty ? '0 : head.data;

  a_r7_hazard_needs_record: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !hazard);

  a_r12_clear_beats_push: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && push_valid) |=> (!head_valid && can_push));

  a_r2_pop_unused_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> head_valid);
endmodule

// File: tb/sim_wbq_scoreboard.sv
module sim_wbq_scoreboard;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid, pop, clear;
  logic [1:0]  push_kind;
  logic [4:0]  push_dest, src_a_idx, src_b_idx;
  logic [31:0] push_data;
  logic        can_push, head_valid, src_a_hit, src_b_hit, hazard;
  logic [1:0]  head_kind;
  logic [4:0]  head_dest;
  logic [31:0] head_data;

  int n_checks = 0;
  int n_err    = 0;

  int          mk[$];
  int          md[$];
  logic [31:0] mv[$];

  always #5 clk = ~clk;

  wbq_scoreboard #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_kind(push_kind),
    .push_dest(push_dest), .push_data(push_data), .can_push(can_push),
    .pop(pop), .clear(clear), .head_valid(head_valid), .head_kind(head_kind),
    .head_dest(head_dest), .head_data(head_data), .src_a_idx(src_a_idx),
    .src_b_idx(src_b_idx), .src_a_hit(src_a_hit), .src_b_hit(src_b_hit),
    .hazard(hazard)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic model_hit(int r);
    for (int i = 0; i < mk.size(); i++)
      if ((mk[i] == 0 || mk[i] == 1) && md[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  // One cycle: drive at the falling edge, check before the rising edge, then advance the model.
  task automatic step(string tag, logic pv, int kind, int dest, logic [31:0] data,
                      logic pp, logic cl, int sa, int sb);
    logic ea, eb;
    bit   was_full, was_empty;
    @(negedge clk);
    push_valid = pv; push_kind = 2'(kind); push_dest = 5'(dest); push_data = data;
    pop = pp; clear = cl; src_a_idx = 5'(sa); src_b_idx = 5'(sb);
    #1;
    ea = model_hit(sa);
    eb = model_hit(sb);
    chk(tag, "src_a_hit", 32'(src_a_hit), 32'(ea));
    chk(tag, "src_b_hit", 32'(src_b_hit), 32'(eb));
    chk(tag, "hazard", 32'(hazard), 32'(ea | eb));
    chk(tag, "can_push", 32'(can_push), 32'(mk.size() < D));
    chk(tag, "head_valid", 32'(head_valid), 32'(mk.size() > 0));
    if (mk.size() > 0) begin
      chk(tag, "head_kind", 32'(head_kind), 32'(mk[0]));
      chk(tag, "head_dest", 32'(head_dest), 32'(md[0]));
      chk(tag, "head_data", head_data, mv[0]);
    end else begin
      chk(tag, "head_data_empty", {25'(0), head_kind, head_dest} | head_data, 32'h0);
    end
    @(posedge clk);
    was_full  = (mk.size() == D);
    was_empty = (mk.size() == 0);
    if (cl) begin
      mk.delete(); md.delete(); mv.delete();
    end else begin
      if (pp && !was_empty) begin
        void'(mk.pop_front()); void'(md.pop_front()); void'(mv.pop_front());
      end
      if (pv && !was_full) begin
        mk.push_back(kind); md.push_back(dest); mv.push_back(data);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    push_valid = 0; pop = 0; clear = 0; push_kind = 0; push_dest = 0;
    push_data = 0; src_a_idx = 0; src_b_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step("R1", 0, 0, 0, 0, 0, 0, 0, 5);
    // R3: ALU record targeting x5
    step("R3", 1, 0, 5, 32'hCAFE0005, 0, 0, 5, 6);
    step("R3", 0, 0, 0, 0, 0, 0, 5, 6);
    // R4: load record targeting x9; R6 both ports differ
    step("R4", 1, 1, 9, 32'h0, 0, 0, 9, 4);
    step("R6", 0, 0, 0, 0, 0, 0, 5, 9);
    step("R6", 0, 0, 0, 0, 0, 0, 9, 12);
    // R5: store and host records with dest 7 never match
    step("R5", 1, 2, 7, 32'h11110007, 0, 0, 7, 7);
    step("R5", 1, 3, 7, 32'h22220007, 0, 0, 7, 7);
    for (int r = 0; r < 32; r += 2) step("R5", 0, 0, 0, 0, 0, 0, r, r + 1);
    // R7: hazard from second port only
    step("R7", 0, 0, 0, 0, 0, 0, 3, 9);
    // R10: queue full, push of ALU x20 dropped
    step("R10", 1, 0, 20, 32'hDEAD0020, 0, 0, 20, 20);
    step("R10", 0, 0, 0, 0, 0, 0, 20, 1);
    // R9: pop head (x5) while searching x5
    step("R9", 0, 0, 0, 0, 1, 0, 5, 0);
    // R8: retired slot no longer matches
    step("R8", 0, 0, 0, 0, 0, 0, 5, 9);
    step("R2", 0, 0, 0, 0, 1, 0, 9, 7);
    step("R2", 0, 0, 0, 0, 1, 0, 7, 9);
    step("R2", 0, 0, 0, 0, 1, 0, 7, 20);
    // R11: pop on empty ignored, push in the same cycle kept
    step("R11", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R11", 1, 0, 14, 32'h14, 1, 0, 14, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 14, 0);
    // R12: clear beats push and pop
    step("R12", 1, 1, 15, 32'h0, 1, 1, 14, 15);
    step("R12", 0, 0, 0, 0, 0, 0, 14, 15);
    // Mixed run with wrap-around and stale matching slots
    for (int n = 0; n < 3000; n++) begin
      step("R2", ($urandom % 100) < 55, $urandom % 4, $urandom % 8, $urandom,
           ($urandom % 100) < 45, ($urandom % 100) < 3, $urandom % 8, $urandom % 8);
    end
    summary();
    $finish;
  end
endmodule